// File: doc/BRIEF.md
# Mode-Filtered Event Counter Bank with Overflow Interrupt

This block holds a bank of programmable event counters for a processor core. Counters sit at indices 3 and up, one slot for each configured counter. A one-cycle increment request names a counter index. The bank adds one to that counter, unless one of three things stops it: the index is not a programmable counter, the counter's global inhibit bit is set, or the counter's own control word blocks counting in the current privilege level and virtualization state.

Each counter is 64 bits wide. A mode input selects how the increment works. In wide mode the counter increments as a single word. In split mode it increments as two 32-bit halves.

When a counter wraps from all-ones to zero, its sticky overflow flag is set. If that flag was clear before the wrap, a shared overflow interrupt request is raised. A two-state machine tracks the interrupt request:

- IRQ_IDLE goes to IRQ_PEND on the transition *raise*.
- IRQ_PEND goes back to IRQ_IDLE on the transition *clear*, which fires when software pulses the clear input and no new raise occurs in the same cycle.

Software reaches the counters and the control words through plain write ports.

Top module: `hpm_bank`

## Requirements
- R1: Only indices FIRST..FIRST+N_PROG-1 (FIRST = 3) are counters. Slot k sits at index 3+k and appears at `cnt_flat[k*64 +: 64]` and at `ovf_flags[k]`. An increment or write to any other index changes nothing.
- R2: An increment is ignored while `inhibit_mask[idx]` is 1.
- R3: Control word bits are: bit0 stops counting in machine mode, bit1 in supervisor mode, bit2 in user mode, bit3 in virtualized supervisor mode, bit4 in virtualized user mode. Bit5 is the overflow flag. The `priv` encoding is 00 user, 01 supervisor, 11 machine. The virtualization bit is ignored in machine mode, and `priv` = 10 is never filtered. An increment is dropped when the bit for the current mode is 1.
- R4: In wide mode (`mode32` = 0) an accepted increment adds one, and all-ones wraps to zero.
- R5: In split mode (`mode32` = 1) there are three cases:
  - If the low half is all-ones and the high half is not, the high half increments and the low half keeps its all-ones value.
  - If both halves are all-ones, both halves clear (a wrap).
  - Otherwise the low half increments.
- R6: A wrap with the overflow flag clear sets the flag and drives `lcof_irq` high one cycle after the request.
- R7: A wrap with the flag already set still clears the counter but raises no new interrupt. The flag stays set.
- R8: `lcof_irq` stays high until `irq_clr` is pulsed. A raise in the same cycle as `irq_clr` wins.
- R9: `cnt_wr_lo` and `cnt_wr_hi` load `cnt_wr_data[31:0]` and `cnt_wr_data[63:32]` into the addressed counter. A write overrides an increment to the same counter in the same cycle.
- R10: A control word write replaces all six bits. Writing bit5 as 0 clears the overflow flag, after which a later wrap raises the interrupt again.
- R11: After reset all counters, control words and flags are zero and `lcof_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_valid | input | 1 | One-cycle increment request |
| inc_idx | input | IDX_W | Counter index of the request |
| priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization mode active |
| inhibit_mask | input | MAX_CTRS | Global per-index inhibit bits |
| mode32 | input | 1 | Split 32-bit counting mode |
| cnt_wr_lo | input | 1 | Write low half of counter |
| cnt_wr_hi | input | 1 | Write high half of counter |
| cnt_wr_idx | input | IDX_W | Counter index for counter write |
| cnt_wr_data | input | 64 | Counter write data |
| ctl_wr_en | input | 1 | Control word write |
| ctl_wr_idx | input | IDX_W | Counter index for control write |
| ctl_wr_data | input | 6 | Control word write data |
| irq_clr | input | 1 | Clear pending overflow interrupt |
| cnt_flat | output | N_PROG*64 | All counter values, slot 0 lowest |
| ovf_flags | output | N_PROG | Sticky overflow flags |
| lcof_irq | output | 1 | Overflow interrupt request |

## Verification
The properties assume that every control input is driven to a known value each cycle. They also assume that a counter changes only through an increment or a counter write. For this reason the checks on unchanged counter values hold only in cycles where neither counter write enable is active. The flag-step and flag-stickiness properties assume that no control word write happens in the cycle being checked. The stimulus changes inputs only on the falling edge and issues at most one increment per clock. It keeps counter writes apart from the increments whose effect it measures, except in the one case that tests write priority.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    localparam int FIRST_PROG = 3;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    // Bit 0 is stop_m, bit 5 is ovf.
    typedef struct packed {
        logic ovf;
        logic stop_vu;
        logic stop_vs;
        logic stop_u;
        logic stop_s;
        logic stop_m;
    } evctl_t;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    function automatic logic mode_blocked(evctl_t c, logic [1:0] p, logic v);
        logic blk;
        unique case (priv_e'(p))
            PRIV_M:   blk = c.stop_m;
            PRIV_S:   blk = v ? c.stop_vs : c.stop_s;
            PRIV_U:   blk = v ? c.stop_vu : c.stop_u;
            PRIV_RSV: blk = 1'b0;
        endcase
        return blk;
    endfunction

endpackage

// File: rtl/hpm_gate.sv
module hpm_gate
    import hpm_pkg::*;
#(
    parameter int MAX_CTRS = 32,
    parameter int N_PROG   = 4,
    parameter int IDX_W    = 5
) (
    input  logic                     inc_valid,
    input  logic [IDX_W-1:0]         inc_idx,
    input  logic [1:0]               priv,
    input  logic                     virt_on,
    input  logic [MAX_CTRS-1:0]      inhibit_mask,
    input  evctl_t [N_PROG-1:0]      ctl_vec,
    output logic [N_PROG-1:0]        bump
);

    logic globally_off;

    always_comb begin
        globally_off = inhibit_mask[inc_idx];
    end

    for (genvar i = 0; i < N_PROG; i++) begin : g_sel
        logic hit;
        always_comb begin
            hit     = inc_valid && (inc_idx == IDX_W'(FIRST_PROG + i));
            bump[i] = hit && !globally_off && !mode_blocked(ctl_vec[i], priv, virt_on);
        end
    end

endmodule

// File: rtl/hpm_slot.sv
module hpm_slot
    import hpm_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bump,
    input  logic          mode32,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [CW-1:0] wr_data,
    input  logic          ctl_we,
    input  evctl_t        ctl_in,
    output logic [CW-1:0] value,
    output evctl_t        ctl_q,
    output logic          raise
);

    localparam int HALF = CW / 2;

    logic [CW-1:0]   value_q;
    logic [CW-1:0]   value_d;
    logic [HALF-1:0] lo_q;
    logic [HALF-1:0] hi_q;
    logic            lo_full;
    logic            at_top;
    logic            wr_any;
    logic [CW-1:0]   stepped;
    evctl_t          ctl_d;

    always_comb begin
        lo_q    = value_q[HALF-1:0];
        hi_q    = value_q[CW-1:HALF];
        lo_full = &lo_q;
        at_top  = &value_q;
        wr_any  = wr_lo | wr_hi;

        if (at_top) begin
            stepped = '0;
        end else if (mode32 && lo_full) begin
            stepped = {hi_q + HALF'(1), lo_q};
        end else if (mode32) begin
            stepped = {hi_q, lo_q + HALF'(1)};
        end else begin
            stepped = value_q + CW'(1);
        end

        value_d = value_q;
        if (wr_any) begin
            if (wr_lo) value_d[HALF-1:0]  = wr_data[HALF-1:0];
            if (wr_hi) value_d[CW-1:HALF] = wr_data[CW-1:HALF];
        end else if (bump) begin
            value_d = stepped;
        end

        raise = bump && !wr_any && at_top && !ctl_q.ovf;

        ctl_d = ctl_q;
        if (ctl_we) begin
            ctl_d = ctl_in;
        end else if (raise) begin
            ctl_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            ctl_q   <= '0;
        end else begin
            value_q <= value_d;
            ctl_q   <= ctl_d;
        end
    end

    always_comb begin
        value = value_q;
    end

endmodule

// File: rtl/hpm_irq_fsm.sv
module hpm_irq_fsm
    import hpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_any,
    input  logic clr,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (raise_any)          state_d = IRQ_PEND;
            IRQ_PEND: if (clr && !raise_any)  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end

endmodule

// File: rtl/hpm_bank.sv
module hpm_bank
    import hpm_pkg::*;
#(
    parameter int MAX_CTRS = 32,
    parameter int N_PROG   = 4,
    parameter int CW       = 64,
    localparam int IDX_W   = $clog2(MAX_CTRS),
    localparam int CTL_W   = $bits(evctl_t)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc_valid,
    input  logic [IDX_W-1:0]       inc_idx,
    input  logic [1:0]             priv,
    input  logic                   virt_on,
    input  logic [MAX_CTRS-1:0]    inhibit_mask,
    input  logic                   mode32,
    input  logic                   cnt_wr_lo,
    input  logic                   cnt_wr_hi,
    input  logic [IDX_W-1:0]       cnt_wr_idx,
    input  logic [CW-1:0]          cnt_wr_data,
    input  logic                   ctl_wr_en,
    input  logic [IDX_W-1:0]       ctl_wr_idx,
    input  logic [CTL_W-1:0]       ctl_wr_data,
    input  logic                   irq_clr,
    output logic [N_PROG*CW-1:0]   cnt_flat,
    output logic [N_PROG-1:0]      ovf_flags,
    output logic                   lcof_irq
);

    if (N_PROG > MAX_CTRS - FIRST_PROG) begin : g_bad_cfg
        $error("hpm_bank: N_PROG exceeds MAX_CTRS - 3");
    end

    evctl_t [N_PROG-1:0] ctl_vec;
    logic   [N_PROG-1:0] bump;
    logic   [N_PROG-1:0] raise_vec;
    logic                raise_any;

    hpm_gate #(
        .MAX_CTRS (MAX_CTRS),
        .N_PROG   (N_PROG),
        .IDX_W    (IDX_W)
    ) u_gate (
        .inc_valid    (inc_valid),
        .inc_idx      (inc_idx),
        .priv         (priv),
        .virt_on      (virt_on),
        .inhibit_mask (inhibit_mask),
        .ctl_vec      (ctl_vec),
        .bump         (bump)
    );

    for (genvar i = 0; i < N_PROG; i++) begin : g_slot
        logic          sel_cnt;
        logic          sel_ctl;
        logic [CW-1:0] val;

        always_comb begin
            sel_cnt = (cnt_wr_idx == IDX_W'(FIRST_PROG + i));
            sel_ctl = (ctl_wr_idx == IDX_W'(FIRST_PROG + i));
        end

        hpm_slot #(.CW(CW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .bump    (bump[i]),
            .mode32  (mode32),
            .wr_lo   (cnt_wr_lo && sel_cnt),
            .wr_hi   (cnt_wr_hi && sel_cnt),
            .wr_data (cnt_wr_data),
            .ctl_we  (ctl_wr_en && sel_ctl),
            .ctl_in  (evctl_t'(ctl_wr_data)),
            .value   (val),
            .ctl_q   (ctl_vec[i]),
            .raise   (raise_vec[i])
        );

        always_comb begin
            cnt_flat[i*CW +: CW] = val;
            ovf_flags[i]         = ctl_vec[i].ovf;
        end
    end

    always_comb begin
        raise_any = |raise_vec;
    end

    hpm_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise_any (raise_any),
        .clr       (irq_clr),
        .irq       (lcof_irq)
    );

endmodule

// File: rtl/hpm_bank_chk.sv
module hpm_bank_chk #(
    parameter int MAX_CTRS = 32,
    parameter int N_PROG   = 4,
    parameter int CW       = 64,
    localparam int IDX_W   = $clog2(MAX_CTRS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 inc_valid,
    input logic [IDX_W-1:0]     inc_idx,
    input logic [MAX_CTRS-1:0]  inhibit_mask,
    input logic                 cnt_wr_lo,
    input logic                 cnt_wr_hi,
    input logic                 ctl_wr_en,
    input logic                 irq_clr,
    input logic [N_PROG*CW-1:0] cnt_flat,
    input logic [N_PROG-1:0]    ovf_flags,
    input logic                 lcof_irq
);

    localparam int FIRST = 3;

    logic no_cnt_wr;
    logic idx_outside;

    always_comb begin
        no_cnt_wr   = !cnt_wr_lo && !cnt_wr_hi;
        idx_outside = (32'(inc_idx) < FIRST) || (32'(inc_idx) >= FIRST + N_PROG);
    end

    p_bad_idx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inc_valid && idx_outside && no_cnt_wr |=> $stable(cnt_flat));

    p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc_valid && inhibit_mask[inc_idx] && no_cnt_wr |=> $stable(cnt_flat));

    p_flag_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_en |=> $countones(ovf_flags) <= $past($countones(ovf_flags)) + 1);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcof_irq) |-> $past(inc_valid));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_en |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lcof_irq && !irq_clr |=> lcof_irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !inc_valid |=> !lcof_irq);

endmodule

bind hpm_bank hpm_bank_chk #(
    .MAX_CTRS (MAX_CTRS),
    .N_PROG   (N_PROG),
    .CW       (CW)
) u_chk (.*);

// File: tb/test_hpm_bank.sv
module test_hpm_bank;

    localparam int MAX_CTRS = 32;
    localparam int N_PROG   = 4;
    localparam int CW       = 64;
    localparam int IDX_W    = $clog2(MAX_CTRS);
    localparam logic [63:0] ONES = '1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 inc_valid = 1'b0;
    logic [IDX_W-1:0]     inc_idx = '0;
    logic [1:0]           priv = 2'b11;
    logic                 virt_on = 1'b0;
    logic [MAX_CTRS-1:0]  inhibit_mask = '0;
    logic                 mode32 = 1'b0;
    logic                 cnt_wr_lo = 1'b0;
    logic                 cnt_wr_hi = 1'b0;
    logic [IDX_W-1:0]     cnt_wr_idx = '0;
    logic [CW-1:0]        cnt_wr_data = '0;
    logic                 ctl_wr_en = 1'b0;
    logic [IDX_W-1:0]     ctl_wr_idx = '0;
    logic [5:0]           ctl_wr_data = '0;
    logic                 irq_clr = 1'b0;
    logic [N_PROG*CW-1:0] cnt_flat;
    logic [N_PROG-1:0]    ovf_flags;
    logic                 lcof_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hpm_bank #(.MAX_CTRS(MAX_CTRS), .N_PROG(N_PROG), .CW(CW)) i_hpm_bank (.*);

    function automatic logic [63:0] cnt_of(int slot);
        return cnt_flat[slot*CW +: CW];
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic inc(int idx);
        inc_valid = 1'b1;
        inc_idx   = IDX_W'(idx);
        @(negedge clk);
        inc_valid = 1'b0;
    endtask

    task automatic wr_cnt(int idx, logic lo, logic hi, logic [63:0] d);
        cnt_wr_idx  = IDX_W'(idx);
        cnt_wr_lo   = lo;
        cnt_wr_hi   = hi;
        cnt_wr_data = d;
        @(negedge clk);
        cnt_wr_lo = 1'b0;
        cnt_wr_hi = 1'b0;
    endtask

    task automatic wr_ctl(int idx, logic [5:0] d);
        ctl_wr_idx  = IDX_W'(idx);
        ctl_wr_data = d;
        ctl_wr_en   = 1'b1;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        for (int s = 0; s < N_PROG; s++) chk("R11 count", cnt_of(s), 64'd0);
        chk("R11 flags", 64'(ovf_flags), 64'd0);
        chk("R11 irq", 64'(lcof_irq), 64'd0);
    endtask

    task automatic t_index();
        inc(2);
        chk("R1 idx2", cnt_flat[255:0] == '0, 1);
        inc(7);
        chk("R1 idx7", cnt_flat[255:0] == '0, 1);
        wr_cnt(2, 1'b1, 1'b1, 64'd55);
        chk("R1 write idx2", cnt_flat[255:0] == '0, 1);
        inc(3);
        chk("R1 idx3 counts", cnt_of(0), 64'd1);
    endtask

    task automatic t_inhibit();
        inhibit_mask[4] = 1'b1;
        inc(4);
        chk("R2 inhibited", cnt_of(1), 64'd0);
        inhibit_mask[4] = 1'b0;
        inc(4);
        chk("R2 released", cnt_of(1), 64'd1);
    endtask

    task automatic t_filter();
        wr_ctl(5, 6'b000010);
        priv = 2'b01; virt_on = 1'b0; inc(5);
        chk("R3 S blocked", cnt_of(2), 64'd0);
        virt_on = 1'b1; inc(5);
        chk("R3 VS counts", cnt_of(2), 64'd1);
        priv = 2'b00; virt_on = 1'b0; inc(5);
        chk("R3 U counts", cnt_of(2), 64'd2);
        priv = 2'b11; inc(5);
        chk("R3 M counts", cnt_of(2), 64'd3);
        wr_ctl(5, 6'b011101);
        priv = 2'b11; virt_on = 1'b1; inc(5);
        chk("R3 M blocked", cnt_of(2), 64'd3);
        priv = 2'b00; inc(5);
        chk("R3 VU blocked", cnt_of(2), 64'd3);
        priv = 2'b01; inc(5);
        chk("R3 VS blocked", cnt_of(2), 64'd3);
        priv = 2'b00; virt_on = 1'b0; inc(5);
        chk("R3 U blocked", cnt_of(2), 64'd3);
        priv = 2'b01; inc(5);
        chk("R3 S counts", cnt_of(2), 64'd4);
        priv = 2'b11;
        wr_ctl(5, 6'b000000);
    endtask

    task automatic t_wrap64();
        wr_cnt(6, 1'b1, 1'b1, ONES - 64'd1);
        inc(6);
        chk("R4 step", cnt_of(3), ONES);
        chk("R6 no flag yet", 64'(ovf_flags[3]), 64'd0);
        inc(6);
        chk("R4 wrap", cnt_of(3), 64'd0);
        chk("R6 flag set", 64'(ovf_flags[3]), 64'd1);
        chk("R6 irq raised", 64'(lcof_irq), 64'd1);
    endtask

    task automatic t_sticky();
        @(negedge clk);
        chk("R8 irq held", 64'(lcof_irq), 64'd1);
        clr_irq();
        chk("R8 irq cleared", 64'(lcof_irq), 64'd0);
        wr_cnt(6, 1'b1, 1'b1, ONES);
        inc(6);
        chk("R7 wrapped", cnt_of(3), 64'd0);
        chk("R7 no new irq", 64'(lcof_irq), 64'd0);
        chk("R7 flag kept", 64'(ovf_flags[3]), 64'd1);
    endtask

    task automatic t_ctl_clear();
        wr_ctl(6, 6'b000000);
        chk("R10 flag cleared", 64'(ovf_flags[3]), 64'd0);
        wr_cnt(6, 1'b1, 1'b1, ONES);
        irq_clr = 1'b1;
        inc(6);
        irq_clr = 1'b0;
        chk("R10 rearmed flag", 64'(ovf_flags[3]), 64'd1);
        chk("R8 raise beats clear", 64'(lcof_irq), 64'd1);
        clr_irq();
        wr_ctl(6, 6'b000000);
    endtask

    task automatic t_split32();
        mode32 = 1'b1;
        wr_cnt(3, 1'b1, 1'b1, {32'd5, 32'hFFFF_FFFF});
        inc(3);
        chk("R5 high bump", cnt_of(0), {32'd6, 32'hFFFF_FFFF});
        inc(3);
        chk("R5 low kept", cnt_of(0), {32'd7, 32'hFFFF_FFFF});
        wr_cnt(3, 1'b1, 1'b0, {32'hAAAA_AAAA, 32'h10});
        chk("R9 low only", cnt_of(0), {32'd7, 32'h10});
        inc(3);
        chk("R5 low step", cnt_of(0), {32'd7, 32'h11});
        wr_cnt(3, 1'b1, 1'b1, ONES);
        inc(3);
        chk("R5 pair wrap", cnt_of(0), 64'd0);
        chk("R6 split flag", 64'(ovf_flags[0]), 64'd1);
        chk("R6 split irq", 64'(lcof_irq), 64'd1);
        clr_irq();
        wr_ctl(3, 6'b000000);
        mode32 = 1'b0;
    endtask

    task automatic t_wr_prio();
        cnt_wr_idx  = IDX_W'(4);
        cnt_wr_lo   = 1'b1;
        cnt_wr_hi   = 1'b1;
        cnt_wr_data = 64'd100;
        inc(4);
        cnt_wr_lo = 1'b0;
        cnt_wr_hi = 1'b0;
        chk("R9 write wins", cnt_of(1), 64'd100);
        inc(4);
        chk("R9 counts after", cnt_of(1), 64'd101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_inhibit();
        t_filter();
        t_wrap64();
        t_sticky();
        t_ctl_clear();
        t_split32();
        t_wr_prio();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule